// File: doc/BRIEF.md
# CPU-to-PCI Outbound Address Decoder

This block sits on the processor side of a host-to-PCI bridge. It inspects each 40-bit CPU physical address and decides whether the address targets this bridge. It also works out which PCI address space is meant and what the PCI-side address is. An address is claimed when its top bit marks a direct I/O access and its bus-group and slot fields equal the block's strap inputs.

Address bits 32:27 select the space through a leading-ones prefix. Sparse spaces carry the PCI address five bits up, with a byte-length code below it. Dense memory passes the address straight through. The low part of each sparse window uses a fixed translation. Above that, the top PCI bits come from software-written high-address extension registers.

The result appears on registered outputs one clock after the request. A request that is not claimed leaves every output at zero.

Top module: `pci_outbound_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every result output becomes zero and all three extension registers clear to zero. Reset is synchronous and active low.
- R2: A request is claimed only when all of these hold: `req_valid` is 1, `req_addr[39]` is 1, `req_addr[38:36]` equals `strap_gid`, and `req_addr[35:33]` equals `strap_mid`. An unclaimed request sets every result output to zero on the next cycle.
- R3: For a claimed request, `req_addr[32:27]` selects the space, reported on `res_space` as follows:
  - `0xxxxx` is sparse memory, code 1.
  - `10xxxx` is dense memory, code 2.
  - `110xxx` is sparse I/O, code 3.
  - `1110xx` is configuration, code 4.
  - `11110x` is bridge CSR, code 5.
  - `111110` is interrupt acknowledge, code 6.
- R4: A claimed request with prefix `111111` gives `res_err`=1, with `res_hit`=0 and all other outputs zero. `res_hit` and `res_err` are never both 1.
- R5: Sparse memory uses region offset `req_addr[31:0]`. When the offset is below 0x2000_0000, `res_pci_addr` is the offset shifted right by 5, so bits 31:24 are zero. `res_blen` equals `req_addr[4:3]` in every sparse space.
- R6: For a sparse-memory offset of 0x2000_0000 or above, `res_pci_addr[26:0]` is the offset shifted right by 5. `res_pci_addr[31:27]` comes from the memory extension register, which holds `cfg_wdata[31:27]`.
- R7: Sparse I/O uses region offset `req_addr[29:0]`.
  - Below 0x20_0000, `res_pci_addr` is the offset shifted right by 5, which is at most 0xFFFF.
  - Otherwise `res_pci_addr[24:0]` is the offset shifted right by 5, and `res_pci_addr[31:25]` comes from the I/O extension register, which holds `cfg_wdata[31:25]`.
- R8: Dense memory gives `res_pci_addr[30:0]` = `req_addr[30:0]` and `res_blen`=0. `res_pci_addr[31]` is the dense extension bit, which holds `cfg_wdata[0]`.
- R9: Configuration space (offset `req_addr[28:0]`) and bridge CSR space (offset `req_addr[27:0]`) give the offset shifted right by 5 on `res_pci_addr`.
- R10: In the interrupt-acknowledge space, offset `req_addr[26:0]` equal to 0x3F00 or 0x3F40 is a hit, with that offset on `res_pci_addr` and `res_blen`=0. Any other offset gives `res_err`=1 and `res_hit`=0.
- R11: When `cfg_we` is 1, `cfg_sel` chooses the register to load: 0 is memory, 1 is I/O, 2 is dense, and 3 writes nothing. A write affects requests from the next cycle on. A request in the same cycle as the write decodes with the old value.
- R12: Each result reflects the request presented at the previous rising clock edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 40 | CPU physical address |
| strap_gid | input | 3 | Own bus-group number |
| strap_mid | input | 3 | Own slot number |
| cfg_we | input | 1 | Extension register write strobe |
| cfg_sel | input | 2 | Extension register select (0 mem, 1 I/O, 2 dense, 3 none) |
| cfg_wdata | input | 32 | Extension register write data |
| res_hit | output | 1 | Request claimed and decoded to a legal target |
| res_space | output | 3 | Space code (0 when not hit) |
| res_pci_addr | output | 32 | PCI-side address |
| res_blen | output | 2 | Byte-length code for sparse spaces |
| res_err | output | 1 | Claimed request aimed at unused space or offset |

## Verification
An extension-register write and a decode that reads that same register can fall in the same cycle. The bench provokes this by issuing a variable-region sparse-memory or sparse-I/O request, or a dense request, in the very cycle that loads the matching register. That result must carry the old upper bits, and a repeat of the request one cycle later must carry the new ones. A random phase mixes writes with requests of every space, so this collision also occurs with unrelated selects and with the ignored select value 3.

// File: rtl/pci_dec_pkg.sv
// Package: shared space codes and address-field constants for the outbound
// decoder. Assumes a 40-bit CPU address with an 8 GB window per bridge node.
package pci_dec_pkg;

    localparam int CPU_AW       = 40;
    localparam int NODE_AW      = 33;
    localparam int ID_W         = 3;
    localparam int SPARSE_SHIFT = 5;
    localparam int PREFIX_W     = 6;

    typedef enum logic [2:0] {
        SP_NONE  = 3'd0,
        SP_SMEM  = 3'd1,
        SP_DENSE = 3'd2,
        SP_SIO   = 3'd3,
        SP_CFG   = 3'd4,
        SP_CSR   = 3'd5,
        SP_IACK  = 3'd6,
        SP_BAD   = 3'd7
    } space_e;

endpackage

// File: rtl/pci_ext_regs.sv
// Module: high-address extension registers for the variable sparse regions
// and the dense window. Assumes writes are single-cycle strobes; select 3 is
// a no-op. All registers clear on synchronous active-low reset.
module pci_ext_regs #(
    parameter int PCI_W      = 32,
    parameter int MEM_HI_LSB = 27,
    parameter int IO_HI_LSB  = 25,
    localparam int MEM_HI_W  = PCI_W - MEM_HI_LSB,
    localparam int IO_HI_W   = PCI_W - IO_HI_LSB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [PCI_W-1:0]    cfg_wdata,
    output logic [MEM_HI_W-1:0] mem_hi,
    output logic [IO_HI_W-1:0]  io_hi,
    output logic                dense_hi
);

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata[IO_HI_LSB-1:1];

    // Load the selected extension register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_hi   <= '0;
            io_hi    <= '0;
            dense_hi <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                2'd0:    mem_hi   <= cfg_wdata[PCI_W-1:MEM_HI_LSB];
                2'd1:    io_hi    <= cfg_wdata[PCI_W-1:IO_HI_LSB];
                2'd2:    dense_hi <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pci_space_class.sv
// Module: leading-ones prefix decoder that names the PCI address space.
// Purely combinational; assumes the prefix field is six bits wide.
module pci_space_class
    import pci_dec_pkg::*;
(
    input  logic [PREFIX_W-1:0] prefix,
    output space_e              space
);

    // Count leading ones of the prefix to pick the space.
    always_comb begin
        casez (prefix)
            6'b0?????: space = SP_SMEM;
            6'b10????: space = SP_DENSE;
            6'b110???: space = SP_SIO;
            6'b1110??: space = SP_CFG;
            6'b11110?: space = SP_CSR;
            6'b111110: space = SP_IACK;
            default:   space = SP_BAD;
        endcase
    end

endmodule

// File: rtl/pci_addr_form.sv
// Module: forms the PCI-side address and byte-length code for a decoded
// space. Combinational; assumes node_ofs is the low 33 bits of the CPU
// address and that extension values are already registered.
module pci_addr_form
    import pci_dec_pkg::*;
#(
    parameter int PCI_W      = 32,
    parameter int MEM_HI_LSB = 27,
    parameter int IO_HI_LSB  = 25,
    parameter int MEM_FIX_W  = 29,
    parameter int IO_FIX_W   = 21,
    parameter logic [26:0] IACK_OFS0 = 27'h3F00,
    parameter logic [26:0] IACK_OFS1 = 27'h3F40,
    localparam int MEM_HI_W  = PCI_W - MEM_HI_LSB,
    localparam int IO_HI_W   = PCI_W - IO_HI_LSB
) (
    input  space_e              space,
    input  logic [NODE_AW-1:0]  node_ofs,
    input  logic [MEM_HI_W-1:0] mem_hi,
    input  logic [IO_HI_W-1:0]  io_hi,
    input  logic                dense_hi,
    output logic [PCI_W-1:0]    pci_addr,
    output logic [1:0]          blen,
    output logic                iack_bad
);

    logic unused_low;
    assign unused_low = ^node_ofs[2:0];

    logic [PCI_W-1:0] smem_sh, sio_sh, cfg_sh, csr_sh;
    logic             smem_var, sio_var;

    // Shift each sparse region offset down to its PCI byte address.
    always_comb begin
        smem_sh  = PCI_W'(node_ofs[31:SPARSE_SHIFT]);
        sio_sh   = PCI_W'(node_ofs[29:SPARSE_SHIFT]);
        cfg_sh   = PCI_W'(node_ofs[28:SPARSE_SHIFT]);
        csr_sh   = PCI_W'(node_ofs[27:SPARSE_SHIFT]);
        smem_var = |node_ofs[31:MEM_FIX_W];
        sio_var  = |node_ofs[29:IO_FIX_W];
    end

    // Select the final address per space; extensions only in variable parts.
    always_comb begin
        pci_addr = '0;
        blen     = node_ofs[4:3];
        iack_bad = 1'b0;
        case (space)
            SP_SMEM: pci_addr = smem_var ? {mem_hi, smem_sh[MEM_HI_LSB-1:0]} : smem_sh;
            SP_SIO:  pci_addr = sio_var  ? {io_hi, sio_sh[IO_HI_LSB-1:0]}   : sio_sh;
            SP_CFG:  pci_addr = cfg_sh;
            SP_CSR:  pci_addr = csr_sh;
            SP_DENSE: begin
                pci_addr = {dense_hi, node_ofs[30:0]};
                blen     = 2'd0;
            end
            SP_IACK: begin
                pci_addr = PCI_W'(node_ofs[26:0]);
                blen     = 2'd0;
                iack_bad = (node_ofs[26:0] != IACK_OFS0) && (node_ofs[26:0] != IACK_OFS1);
            end
            default: blen = 2'd0;
        endcase
    end

endmodule

// File: rtl/pci_outbound_decoder.sv
// Module: top of the CPU-to-PCI outbound decoder. Claims addresses that
// carry the direct-I/O bit and this node's straps, classifies the space,
// forms the PCI address and registers the result one cycle later.
// Assumes straps are static while requests are presented.
module pci_outbound_decoder
    import pci_dec_pkg::*;
#(
    parameter int PCI_W      = 32,
    parameter int MEM_HI_LSB = 27,
    parameter int IO_HI_LSB  = 25,
    localparam int MEM_HI_W  = PCI_W - MEM_HI_LSB,
    localparam int IO_HI_W   = PCI_W - IO_HI_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CPU_AW-1:0] req_addr,
    input  logic [ID_W-1:0]   strap_gid,
    input  logic [ID_W-1:0]   strap_mid,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PCI_W-1:0]  cfg_wdata,
    output logic              res_hit,
    output logic [2:0]        res_space,
    output logic [PCI_W-1:0]  res_pci_addr,
    output logic [1:0]        res_blen,
    output logic              res_err
);

    logic [MEM_HI_W-1:0] mem_hi;
    logic [IO_HI_W-1:0]  io_hi;
    logic                dense_hi;
    space_e              space;
    logic [PCI_W-1:0]    pci_c;
    logic [1:0]          blen_c;
    logic                iack_bad, claim, err_c, hit_c;

    pci_ext_regs #(.PCI_W(PCI_W), .MEM_HI_LSB(MEM_HI_LSB), .IO_HI_LSB(IO_HI_LSB)) i_ext (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_hi(mem_hi), .io_hi(io_hi), .dense_hi(dense_hi)
    );

    pci_space_class i_cls (
        .prefix(req_addr[NODE_AW-1:NODE_AW-PREFIX_W]),
        .space(space)
    );

    pci_addr_form #(.PCI_W(PCI_W), .MEM_HI_LSB(MEM_HI_LSB), .IO_HI_LSB(IO_HI_LSB)) i_form (
        .space(space), .node_ofs(req_addr[NODE_AW-1:0]), .mem_hi(mem_hi),
        .io_hi(io_hi), .dense_hi(dense_hi), .pci_addr(pci_c), .blen(blen_c),
        .iack_bad(iack_bad)
    );

    // Decide whether this node owns the request and whether it is legal.
    always_comb begin
        claim = req_valid && req_addr[CPU_AW-1]
             && (req_addr[CPU_AW-2 -: ID_W] == strap_gid)
             && (req_addr[CPU_AW-2-ID_W -: ID_W] == strap_mid);
        err_c = claim && ((space == SP_BAD) || ((space == SP_IACK) && iack_bad));
        hit_c = claim && !err_c;
    end

    // Register the result; anything but a legal hit leaves outputs idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !hit_c) begin
            res_hit      <= 1'b0;
            res_space    <= SP_NONE;
            res_pci_addr <= '0;
            res_blen     <= 2'd0;
        end else begin
            res_hit      <= 1'b1;
            res_space    <= space;
            res_pci_addr <= pci_c;
            res_blen     <= blen_c;
        end
    end

    // Register the error flag separately from the hit path.
    always_ff @(posedge clk) begin
        if (!rst_n) res_err <= 1'b0;
        else        res_err <= err_c;
    end

endmodule

// File: rtl/pci_outbound_decoder_chk.sv
// Module: property checker bound to the outbound decoder. Observes ports
// only; assumes a synchronous active-low reset.
module pci_outbound_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [39:0] req_addr,
    input logic [2:0]  strap_gid,
    input logic [2:0]  strap_mid,
    input logic        res_hit,
    input logic [2:0]  res_space,
    input logic [31:0] res_pci_addr,
    input logic [1:0]  res_blen,
    input logic        res_err
);

    logic own;
    assign own = req_valid && req_addr[39] && (req_addr[38:36] == strap_gid)
              && (req_addr[35:33] == strap_mid);

    AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !own |=> (!res_hit && !res_err && res_space == 3'd0 && res_pci_addr == 32'd0)); // R2

    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_space == 3'd0 && res_pci_addr == 32'd0 && res_blen == 2'd0)); // R2

    AST_HIT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_hit && res_err)); // R4

    AST_BAD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (own && req_addr[32:27] == 6'h3F) |=> res_err); // R4

    AST_SMEM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (own && !req_addr[32] && req_addr[31:29] == 3'd0)
        |=> (res_hit && res_pci_addr[31:24] == 8'd0 && res_blen == $past(req_addr[4:3]))); // R5

    AST_DENSE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (own && req_addr[32:31] == 2'b10)
        |=> (res_space == 3'd2 && res_pci_addr[30:0] == $past(req_addr[30:0]))); // R8

endmodule

bind pci_outbound_decoder pci_outbound_decoder_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .strap_gid(strap_gid), .strap_mid(strap_mid), .res_hit(res_hit),
    .res_space(res_space), .res_pci_addr(res_pci_addr), .res_blen(res_blen),
    .res_err(res_err)
);

// File: tb/test_pci_outbound_decoder.sv
module test_pci_outbound_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic [2:0]  strap_gid = 3'd5;
    logic [2:0]  strap_mid = 3'd2;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        res_hit, res_err;
    logic [2:0]  res_space;
    logic [31:0] res_pci_addr;
    logic [1:0]  res_blen;

    int tests = 0;
    int fails = 0;
    longint m_mem = 0, m_io = 0, m_dense = 0;

    always #2 clk = ~clk;

    pci_outbound_decoder i_pci_outbound_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .strap_gid(strap_gid), .strap_mid(strap_mid), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .res_hit(res_hit),
        .res_space(res_space), .res_pci_addr(res_pci_addr), .res_blen(res_blen),
        .res_err(res_err)
    );

    // Behavioural reference: {hit, space, pci, blen, err}
    function automatic logic [38:0] model(input logic v, input logic [39:0] a);
        longint off, o, pci;
        int sp;
        logic er;
        if (!v || !a[39] || a[38:36] != strap_gid || a[35:33] != strap_mid) return '0;
        off = longint'(a[32:0]);
        er = 1'b0; pci = 0; sp = 0;
        if (off < 64'h1_0000_0000) begin
            sp = 1; o = off;
            pci = (o < 64'h2000_0000) ? o / 32 : o / 32 + (m_mem & 64'hF800_0000);
        end else if (off < 64'h1_8000_0000) begin
            sp = 2; pci = (off - 64'h1_0000_0000) + ((m_dense % 2) * 64'h8000_0000);
        end else if (off < 64'h1_C000_0000) begin
            sp = 3; o = off - 64'h1_8000_0000;
            pci = (o < 64'h20_0000) ? o / 32 : o / 32 + (m_io & 64'hFE00_0000);
        end else if (off < 64'h1_E000_0000) begin
            sp = 4; pci = (off - 64'h1_C000_0000) / 32;
        end else if (off < 64'h1_F000_0000) begin
            sp = 5; pci = (off - 64'h1_E000_0000) / 32;
        end else if (off < 64'h1_F800_0000) begin
            o = off - 64'h1_F000_0000;
            if (o == 64'h3F00 || o == 64'h3F40) begin sp = 6; pci = o; end
            else er = 1'b1;
        end else er = 1'b1;
        if (er) return {1'b0, 3'd0, 32'd0, 2'd0, 1'b1};
        return {1'b1, 3'(sp), 32'(pci), ((sp == 2 || sp == 6) ? 2'd0 : a[4:3]), 1'b0};
    endfunction

    function automatic logic [39:0] mk(input logic [32:0] node);
        return {1'b1, strap_gid, strap_mid, node};
    endfunction

    // One clock: drive, predict with old registers, update model, compare.
    task automatic cyc(input string tag, input logic v, input logic [39:0] a,
                       input logic we = 1'b0, input logic [1:0] sel = 2'd0,
                       input logic [31:0] wd = 32'd0);
        logic [38:0] exp, act;
        @(negedge clk);
        req_valid = v; req_addr = a; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        exp = rst_n ? model(v, a) : '0;
        if (!rst_n) begin m_mem = 0; m_io = 0; m_dense = 0; end
        else if (we) begin
            if (sel == 2'd0) m_mem = longint'(wd);
            else if (sel == 2'd1) m_io = longint'(wd);
            else if (sel == 2'd2) m_dense = longint'(wd);
        end
        @(posedge clk); #1;
        act = {res_hit, res_space, res_pci_addr, res_blen, res_err};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h act hit=%0d sp=%0d pci=%h bl=%0d err=%0d exp hit=%0d sp=%0d pci=%h bl=%0d err=%0d",
                     tag, a, act[38], act[37:35], act[34:3], act[2:1], act[0],
                     exp[38], exp[37:35], exp[34:3], exp[2:1], exp[0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset dominates a valid request and a write
        cyc("R1", 1'b1, mk(33'h0_0000_1238), 1'b1, 2'd0, 32'hFFFF_FFFF);
        cyc("R1", 1'b1, mk(33'h1_0000_0040));
        @(negedge clk); rst_n = 1'b1;
        cyc("R1", 1'b1, mk(33'h0_4000_0020));        // ext regs still zero
        // R2: claim conditions
        cyc("R2", 1'b0, mk(33'h0_0000_1238));
        cyc("R2", 1'b1, {1'b0, mk(33'h0_0000_1238)} [39:0] & 40'h7F_FFFF_FFFF);
        cyc("R2", 1'b1, {1'b1, 3'd4, 3'd2, 33'h0_0000_1238});
        cyc("R2", 1'b1, {1'b1, 3'd5, 3'd3, 33'h0_0000_1238});
        // R5 sparse memory fixed, blen, R12 latency back-to-back
        cyc("R5", 1'b1, mk(33'h0_0000_1238));
        cyc("R12", 1'b1, mk(33'h0_1FFF_FFF8));
        // R6 / R11: write in same cycle as variable request, then after
        cyc("R11", 1'b1, mk(33'h0_2000_0010), 1'b1, 2'd0, 32'hA800_0000);
        cyc("R6", 1'b1, mk(33'h0_2000_0010));
        cyc("R6", 1'b1, mk(33'h0_FFFF_FFF8));
        // R7 sparse I/O fixed and variable
        cyc("R7", 1'b1, mk(33'h1_801F_FFE8));
        cyc("R11", 1'b1, mk(33'h1_8020_0008), 1'b1, 2'd1, 32'h5600_0000);
        cyc("R7", 1'b1, mk(33'h1_8020_0008));
        cyc("R7", 1'b1, mk(33'h1_BFFF_FFF0));
        // R8 dense, extension bit clear then set
        cyc("R8", 1'b1, mk(33'h1_7FFF_FFFF));
        cyc("R11", 1'b1, mk(33'h1_1234_5678), 1'b1, 2'd2, 32'h0000_0001);
        cyc("R8", 1'b1, mk(33'h1_1234_5678));
        // R11: select 3 ignored, checked through all three spaces
        cyc("R11", 1'b0, mk(33'h0), 1'b1, 2'd3, 32'h0000_0000);
        cyc("R11", 1'b1, mk(33'h0_3000_0000));
        cyc("R11", 1'b1, mk(33'h1_A000_0000));
        cyc("R11", 1'b1, mk(33'h1_0000_0000));
        // R9 config and CSR
        cyc("R9", 1'b1, mk(33'h1_C123_4568));
        cyc("R9", 1'b1, mk(33'h1_EFFF_FFF8));
        // R10 interrupt acknowledge
        cyc("R10", 1'b1, mk(33'h1_F000_3F00));
        cyc("R10", 1'b1, mk(33'h1_F000_3F40));
        cyc("R10", 1'b1, mk(33'h1_F000_3F20));
        // R4 unused space
        cyc("R4", 1'b1, mk(33'h1_F800_0000));
        cyc("R4", 1'b1, mk(33'h1_FFFF_FFFF));
        // R3 random mix of all spaces with interleaved writes
        for (int i = 0; i < 400; i++) begin
            logic [32:0] node;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 7));
            node = {$urandom, $urandom} [32:0];
            case (pick)
                3'd0: node[32] = 1'b0;
                3'd1: node[32:31] = 2'b10;
                3'd2: node[32:30] = 3'b110;
                3'd3: node[32:29] = 4'b1110;
                3'd4: node[32:28] = 5'b11110;
                3'd5: node = 33'h1_F000_3F00 | (($urandom % 2) ? 33'h40 : 33'h0);
                default: ;
            endcase
            cyc("R3", ($urandom % 8) != 0, mk(node), ($urandom % 4) == 0,
                2'($urandom), $urandom);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule